// File: doc/BRIEF.md
# Four-Lane Fixed-Point Vector Transform Pipeline

This block is a four-lane signed fixed-point multiply-accumulate pipeline for vertex arithmetic. Each lane holds a 32-bit Q16.16 value. The pipeline takes one single-cycle instruction per clock. A lane-wise multiply (MUL) or multiply-add (MAD) finishes four clocks after it is accepted. A fused transform computes the product of a 4x4 matrix and a 4-component vector, with the matrix supplied as four column vectors.

Each 32x32 lane product is split across four stages:
- E1 forms the partial product of the operand with the unsigned low half of the multiplier.
- E2 forms the partial product with the signed high half.
- E3 adds the low 32 bits of the running sum. It passes a two-bit carry forward.
- E4 adds the high 32 bits.

A transform goes in as four back-to-back steps. The first is a MUL with the vector's x component broadcast to all lanes against column 0. Then come MADs with y, z and w against columns 1, 2 and 3. Each chained step does not use an addend. It reads the previous step's low word from the E3 register and its high word from the E4 register, which bypasses the partial sum without writing it back. A new transform can start in every fourth cycle.

A small sequencer issues the steps. It has four states:
- `SEQ_IDLE` accepts a start or a single instruction.
- `SEQ_STEP_Y`, `SEQ_STEP_Z` and `SEQ_STEP_W` issue the three chained MADs.

It has four transitions:
- `SEQ_IDLE` goes to `SEQ_STEP_Y` on a start (the "launch" transition). With no start it stays in `SEQ_IDLE`.
- `SEQ_STEP_Y` goes to `SEQ_STEP_Z` unconditionally ("advance-y").
- `SEQ_STEP_Z` goes to `SEQ_STEP_W` unconditionally ("advance-z").
- `SEQ_STEP_W` goes to `SEQ_IDLE` unconditionally ("retire").

Top module: `xform_mac_unit`

## Requirements
- R1: While reset is low, and directly after it is released, `out_valid` is 0 and `out_data` is all zeros.
- R2: In `SEQ_IDLE`, `in_valid`=1 with `in_mad`=0 and `start`=0 issues a MUL. Lane i of the result (bits 32i+31..32i) is bits 47..16 of the exact signed 64-bit product of `vec_in` lane i and `col0_in` lane i. This is Q16.16 truncation toward minus infinity.
- R3: With `in_mad`=1 the same issue is a MAD. The value `col1_in` lane i, shifted left by 16 and sign-extended, is added to the exact product before bits 47..16 are taken.
- R4: A single instruction sampled at a rising edge produces `out_valid`=1 and its result after the fourth rising edge. A new instruction can be accepted on every clock, back to back.
- R5: `start`=1 in `SEQ_IDLE` launches a transform. Lane i of its result is bits 47..16 of the exact sum over k=0..3 of `vec_in` component k (bits 32k+31..32k) times column k lane i. The result and a single `out_valid` pulse appear after the seventh rising edge, counting the start edge as the first.
- R6: The vector and columns 1..3 are captured at the start edge. Changing them in the following three cycles does not alter the transform result.
- R7: In `SEQ_STEP_Y`, `SEQ_STEP_Z` and `SEQ_STEP_W`, the inputs `in_valid` and `start` are ignored. They produce no result pulse.
- R8: When `start` and `in_valid` are both 1 in `SEQ_IDLE`, the transform is launched and the single instruction is dropped.
- R9: A start in the cycle right after `SEQ_STEP_W` is accepted. Back-to-back transforms deliver one result every four cycles.
- R10: `out_valid` pulses exactly once for each completed MUL, MAD or transform. `out_data` holds the last result between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue a single lane-wise MUL or MAD |
| in_mad | input | 1 | 1 selects MAD, 0 selects MUL for a single issue |
| start | input | 1 | Launch a fused 4x4 transform |
| vec_in | input | 128 | Lane operand for single ops; x,y,z,w components for a transform (lane/component k at bits 32k+31..32k) |
| col0_in | input | 128 | Multiplier for single ops; matrix column 0 |
| col1_in | input | 128 | Addend for MAD; matrix column 1 |
| col2_in | input | 128 | Matrix column 2 |
| col3_in | input | 128 | Matrix column 3 |
| out_valid | output | 1 | One-cycle pulse per completed result |
| out_data | output | 128 | Four Q16.16 result lanes, held between pulses |

## Verification
The bench sweeps every pair from a set of edge values through MUL and MAD, and through transforms that chain those values. The set includes 0, ±1.0, 0.5, the most positive and most negative words, and the smallest negative fraction. A broken partial-product split or a lost two-bit carry would corrupt the high word, and sign-extension errors would show on the most negative operands. During the busy cycles the bench drives decoy starts, decoy single issues and scrambled operands. A sequencer that stopped capturing operands would return a mixed-up transform, and one that stopped gating inputs would emit extra result pulses. Back-to-back transforms, issues on every clock and a single issue right after `SEQ_STEP_W` test the bypass timing: a stale or early bypass would fold the previous result into the next one.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

    // Default geometry: four lanes of Q16.16
    localparam int XF_LANES = 4;
    localparam int XF_WORD  = 32;
    localparam int XF_FRAC  = 16;

    // Issue sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STEP_Y = 2'd1,
        SEQ_STEP_Z = 2'd2,
        SEQ_STEP_W = 2'd3
    } seq_state_t;

    // Control tag travelling beside each pipeline slot
    typedef struct packed {
        logic vld;    // slot holds an issued step
        logic chain;  // accumulate onto the previous step via bypass
        logic last;   // completing this step yields a visible result
    } slot_tag_t;

endpackage

// File: rtl/xfm_seq.sv
module xfm_seq
    import xfm_pkg::*;
#(
    parameter int LANES = XF_LANES,
    parameter int WORD  = XF_WORD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     in_valid,
    input  logic                     in_mad,
    input  logic [LANES*WORD-1:0]    vec_in,
    input  logic [LANES*LANES*WORD-1:0] col_in,
    output logic [LANES*WORD-1:0]    iss_a,
    output logic [LANES*WORD-1:0]    iss_b,
    output logic [LANES*WORD-1:0]    iss_c,
    output logic                     iss_mad,
    output slot_tag_t                iss_tag,
    output seq_state_t               state_o
);

    localparam int VW = LANES * WORD;

    seq_state_t state_q, state_d;

    // Components y..w and columns 1..3, frozen at launch
    logic [VW-WORD-1:0]       vec_q;
    logic [(LANES-1)*VW-1:0]  mat_q;

    logic launch;
    assign launch = (state_q == SEQ_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: launch, advance-y, advance-z, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   state_d = start ? SEQ_STEP_Y : SEQ_IDLE;
            SEQ_STEP_Y: state_d = SEQ_STEP_Z;
            SEQ_STEP_Z: state_d = SEQ_STEP_W;
            SEQ_STEP_W: state_d = SEQ_IDLE;
        endcase
    end

    // Operand capture at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            mat_q <= '0;
        end else if (launch) begin
            vec_q <= vec_in[VW-1:WORD];
            mat_q <= col_in[LANES*VW-1:VW];
        end
    end

    // Issue selection per state
    always_comb begin
        iss_a   = '0;
        iss_b   = '0;
        iss_c   = '0;
        iss_mad = 1'b0;
        iss_tag = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    iss_a   = {LANES{vec_in[WORD-1:0]}};
                    iss_b   = col_in[VW-1:0];
                    iss_tag = '{vld: 1'b1, chain: 1'b0, last: 1'b0};
                end else if (in_valid) begin
                    iss_a   = vec_in;
                    iss_b   = col_in[VW-1:0];
                    iss_c   = col_in[2*VW-1:VW];
                    iss_mad = in_mad;
                    iss_tag = '{vld: 1'b1, chain: 1'b0, last: 1'b1};
                end
            end
            SEQ_STEP_Y: begin
                iss_a   = {LANES{vec_q[0 +: WORD]}};
                iss_b   = mat_q[0 +: VW];
                iss_tag = '{vld: 1'b1, chain: 1'b1, last: 1'b0};
            end
            SEQ_STEP_Z: begin
                iss_a   = {LANES{vec_q[WORD +: WORD]}};
                iss_b   = mat_q[VW +: VW];
                iss_tag = '{vld: 1'b1, chain: 1'b1, last: 1'b0};
            end
            SEQ_STEP_W: begin
                iss_a   = {LANES{vec_q[2*WORD +: WORD]}};
                iss_b   = mat_q[2*VW +: VW];
                iss_tag = '{vld: 1'b1, chain: 1'b1, last: 1'b1};
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/xfm_lane.sv
module xfm_lane
    import xfm_pkg::*;
#(
    parameter int WORD = XF_WORD,
    parameter int FRAC = XF_FRAC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WORD-1:0] a,
    input  logic [WORD-1:0] b,
    input  logic [WORD-1:0] c,
    input  logic            mad,
    input  logic            e3_chain,  // tag of the slot now leaving E2
    input  logic            e4_chain,  // tag of the slot now leaving E3
    input  logic            e4_cap,    // that slot completes a result
    output logic [WORD-1:0] res
);

    localparam int HALF = WORD / 2;
    localparam int PW   = WORD + HALF;   // partial-product width
    localparam int DW   = 2 * WORD;      // accumulator width

    // ---------------- E1: operand x unsigned low half ----------------
    logic signed [PW-1:0] plo_n;
    logic signed [DW-1:0] c_sh;
    assign plo_n = PW'($signed(a)) * PW'($signed({1'b0, b[HALF-1:0]}));
    assign c_sh  = DW'($signed(c)) <<< FRAC;

    logic [WORD-1:0] e1_a;
    logic [HALF-1:0] e1_bh;
    logic [PW-1:0]   e1_plo;
    logic [WORD-1:0] e1_clo, e1_chi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e1_a <= '0; e1_bh <= '0; e1_plo <= '0; e1_clo <= '0; e1_chi <= '0;
        end else begin
            e1_a   <= a;
            e1_bh  <= b[WORD-1:HALF];
            e1_plo <= plo_n;
            e1_clo <= mad ? c_sh[WORD-1:0]  : '0;
            e1_chi <= mad ? c_sh[DW-1:WORD] : '0;
        end
    end

    // ---------------- E2: operand x signed high half -----------------
    logic signed [PW-1:0] phi_n;
    assign phi_n = PW'($signed(e1_a)) * PW'($signed(e1_bh));

    logic [PW-1:0]   e2_plo, e2_phi;
    logic [WORD-1:0] e2_clo, e2_chi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e2_plo <= '0; e2_phi <= '0; e2_clo <= '0; e2_chi <= '0;
        end else begin
            e2_plo <= e1_plo;
            e2_phi <= phi_n;
            e2_clo <= e1_clo;
            e2_chi <= e1_chi;
        end
    end

    // ---------------- E3: low word sum, carry kept apart --------------
    logic [WORD-1:0] e3_lo;
    logic [1:0]      e3_cy;
    logic [HALF-1:0] e3_plo_top;
    logic [WORD-1:0] e3_phi_top, e3_chi;

    logic [WORD-1:0] acc_lo;
    logic [WORD+1:0] lo_sum;
    assign acc_lo = e3_chain ? e3_lo : e2_clo;   // bypass of previous low word
    assign lo_sum = {2'b00, e2_plo[WORD-1:0]}
                  + {2'b00, e2_phi[WORD-HALF-1:0], {HALF{1'b0}}}
                  + {2'b00, acc_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e3_lo <= '0; e3_cy <= '0; e3_plo_top <= '0; e3_phi_top <= '0; e3_chi <= '0;
        end else begin
            e3_lo      <= lo_sum[WORD-1:0];
            e3_cy      <= lo_sum[WORD+1:WORD];
            e3_plo_top <= e2_plo[PW-1:WORD];
            e3_phi_top <= e2_phi[PW-1:HALF];
            e3_chi     <= e2_chi;
        end
    end

    // ---------------- E4: high word sum and extract -------------------
    logic [WORD-1:0] e4_hi;
    logic [WORD-1:0] acc_hi, hi_n;
    logic [DW-1:0]   full_n;
    assign acc_hi = e4_chain ? e4_hi : e3_chi;   // bypass of previous high word
    assign hi_n   = {{(WORD-HALF){e3_plo_top[HALF-1]}}, e3_plo_top}
                  + e3_phi_top
                  + acc_hi
                  + {{(WORD-2){1'b0}}, e3_cy};
    assign full_n = {hi_n, e3_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e4_hi <= '0;
            res   <= '0;
        end else begin
            e4_hi <= hi_n;
            if (e4_cap) begin
                res <= full_n[FRAC +: WORD];
            end
        end
    end

endmodule

// File: rtl/xfm_tagpipe.sv
module xfm_tagpipe
    import xfm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  slot_tag_t iss_tag,
    output logic      e3_chain,
    output logic      e4_chain,
    output logic      e4_cap,
    output logic      out_valid
);

    slot_tag_t t1_q, t2_q, t3_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_q      <= '0;
            t2_q      <= '0;
            t3_q      <= '0;
            out_valid <= 1'b0;
        end else begin
            t1_q      <= iss_tag;
            t2_q      <= t1_q;
            t3_q      <= t2_q;
            out_valid <= t3_q.vld & t3_q.last;
        end
    end

    assign e3_chain = t2_q.chain;
    assign e4_chain = t3_q.chain;
    assign e4_cap   = t3_q.vld & t3_q.last;

endmodule

// File: rtl/xform_mac_unit.sv
module xform_mac_unit
    import xfm_pkg::*;
#(
    parameter int WORD = XF_WORD,
    parameter int FRAC = XF_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_mad,
    input  logic                    start,
    input  logic [XF_LANES*WORD-1:0] vec_in,
    input  logic [XF_LANES*WORD-1:0] col0_in,
    input  logic [XF_LANES*WORD-1:0] col1_in,
    input  logic [XF_LANES*WORD-1:0] col2_in,
    input  logic [XF_LANES*WORD-1:0] col3_in,
    output logic                    out_valid,
    output logic [XF_LANES*WORD-1:0] out_data
);

    localparam int LANES = XF_LANES;
    localparam int VW    = LANES * WORD;

    logic [LANES*VW-1:0] col_all;
    assign col_all = {col3_in, col2_in, col1_in, col0_in};

    logic [VW-1:0] iss_a, iss_b, iss_c;
    logic          iss_mad;
    slot_tag_t     iss_tag;
    seq_state_t    seq_state;

    xfm_seq #(.LANES(LANES), .WORD(WORD)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .in_mad   (in_mad),
        .vec_in   (vec_in),
        .col_in   (col_all),
        .iss_a    (iss_a),
        .iss_b    (iss_b),
        .iss_c    (iss_c),
        .iss_mad  (iss_mad),
        .iss_tag  (iss_tag),
        .state_o  (seq_state)
    );

    logic e3_chain, e4_chain, e4_cap;

    xfm_tagpipe u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_tag   (iss_tag),
        .e3_chain  (e3_chain),
        .e4_chain  (e4_chain),
        .e4_cap    (e4_cap),
        .out_valid (out_valid)
    );

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        xfm_lane #(.WORD(WORD), .FRAC(FRAC)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .a        (iss_a[gi*WORD +: WORD]),
            .b        (iss_b[gi*WORD +: WORD]),
            .c        (iss_c[gi*WORD +: WORD]),
            .mad      (iss_mad),
            .e3_chain (e3_chain),
            .e4_chain (e4_chain),
            .e4_cap   (e4_cap),
            .res      (out_data[gi*WORD +: WORD])
        );
    end

endmodule

// File: rtl/xfm_chk.sv
module xfm_chk
    import xfm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_valid,
    input logic       out_valid,
    input seq_state_t seq_state
);

    // R4
    single_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_IDLE && in_valid && !start) |-> ##4 out_valid);

    // R5
    xform_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_IDLE && start) |-> ##7 out_valid);

    // R9
    launch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_IDLE && start) |=> (seq_state == SEQ_STEP_Y));

    // R9
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_STEP_W) |=> (seq_state == SEQ_IDLE));

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_STEP_Y || seq_state == SEQ_STEP_Z) |-> ##4 !out_valid);

endmodule

bind xform_mac_unit xfm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .seq_state (seq_state)
);

// File: tb/sim_xform_mac_unit.sv
module sim_xform_mac_unit;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, in_valid, in_mad, start;
    logic [127:0] vec_in, col0_in, col1_in, col2_in, col3_in;
    logic         out_valid;
    logic [127:0] out_data;

    xform_mac_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mad(in_mad), .start(start),
        .vec_in(vec_in), .col0_in(col0_in), .col1_in(col1_in), .col2_in(col2_in),
        .col3_in(col3_in), .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    bit mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [127:0] exp_val [0:1023];
    int           exp_due [0:1023];
    string        exp_tag [0:1023];
    int           wr_i = 0;
    int           rd_i = 0;
    logic [127:0] last_out = '0;

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] edge_val(int k);
        case (k % 8)
            0: return 32'h0000_0000;
            1: return 32'h0001_0000;   // +1.0
            2: return 32'hFFFF_0000;   // -1.0
            3: return 32'h0000_8000;   // +0.5
            4: return 32'h7FFF_FFFF;   // most positive
            5: return 32'h8000_0000;   // most negative
            6: return 32'hFFFF_FFFF;   // smallest negative fraction
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [127:0] mkv(int base, int step);
        logic [127:0] v;
        for (int l = 0; l < 4; l++) v[32*l +: 32] = edge_val(base + step * l);
        return v;
    endfunction

    function automatic longint sx(logic [31:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [127:0] model_single(bit mad, logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [127:0] r;
        for (int l = 0; l < 4; l++) begin
            longint s;
            s = sx(a[32*l +: 32]) * sx(b[32*l +: 32]);
            if (mad) s = s + (sx(c[32*l +: 32]) <<< 16);
            r[32*l +: 32] = s[47:16];
        end
        return r;
    endfunction

    function automatic logic [127:0] model_xform(logic [127:0] v, logic [127:0] m0, logic [127:0] m1,
                                                 logic [127:0] m2, logic [127:0] m3);
        logic [127:0] r;
        for (int l = 0; l < 4; l++) begin
            longint s;
            s = sx(v[31:0])   * sx(m0[32*l +: 32])
              + sx(v[63:32])  * sx(m1[32*l +: 32])
              + sx(v[95:64])  * sx(m2[32*l +: 32])
              + sx(v[127:96]) * sx(m3[32*l +: 32]);
            r[32*l +: 32] = s[47:16];
        end
        return r;
    endfunction

    task automatic push_exp(logic [127:0] v, int due, string tag);
        exp_val[wr_i] = v;
        exp_due[wr_i] = due;
        exp_tag[wr_i] = tag;
        wr_i++;
    endtask

    // Single MUL/MAD issue, one cycle
    task automatic do_single(bit mad, logic [127:0] a, logic [127:0] b, logic [127:0] c, string tag);
        in_valid = 1'b1; in_mad = mad; start = 1'b0;
        vec_in = a; col0_in = b; col1_in = c;
        push_exp(model_single(mad, a, b, c), cyc + 4, tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Transform launch plus its three busy cycles
    task automatic do_xform(logic [127:0] v, logic [127:0] m0, logic [127:0] m1, logic [127:0] m2,
                            logic [127:0] m3, bit decoy, bit both, string tag);
        start = 1'b1; in_valid = both; in_mad = 1'b1;
        vec_in = v; col0_in = m0; col1_in = m1; col2_in = m2; col3_in = m3;
        push_exp(model_xform(v, m0, m1, m2, m3), cyc + 7, tag);
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        for (int s = 0; s < 3; s++) begin
            if (decoy) begin
                start = 1'b1; in_valid = 1'b1; in_mad = s[0];
                vec_in = ~vec_in; col0_in = ~col0_in; col1_in = col1_in ^ 128'h5A5A;
                col2_in = {col2_in[63:0], col2_in[127:64]}; col3_in = ~col3_in;
            end
            @(negedge clk);
        end
        start = 1'b0; in_valid = 1'b0;
    endtask

    // Result monitor (R4, R5, R7, R10 checked here against the expected stream)
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (rd_i >= wr_i) begin
                    check(1'b0, "R7", "unexpected result pulse", out_data, last_out);
                end else begin
                    check(out_data === exp_val[rd_i], exp_tag[rd_i], "result value", out_data, exp_val[rd_i]);
                    check(cyc == exp_due[rd_i], exp_tag[rd_i], "result cycle", 128'(cyc), 128'(exp_due[rd_i]));
                    last_out = out_data;
                    rd_i++;
                end
            end else begin
                check(out_data === last_out, "R10", "hold between results", out_data, last_out);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog expired act=%0d exp=%0d", rd_i, wr_i);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] idv [0:3];
        rst_n = 1'b0; in_valid = 1'b0; in_mad = 1'b0; start = 1'b0;
        vec_in = '0; col0_in = '0; col1_in = '0; col2_in = '0; col3_in = '0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", "valid in reset", 128'(out_valid), 128'(0));
        check(out_data === '0, "R1", "data in reset", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "valid after reset", 128'(out_valid), 128'(0));
        check(out_data === '0, "R1", "data after reset", out_data, '0);
        mon_on = 1'b1;

        // R2: every value pair through MUL, back to back
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                do_single(1'b0, mkv(i, 0), mkv(j, 1), mkv(i + j, 3), "R2");
        repeat (6) @(negedge clk);

        // R3: every pair through MAD with rotating addends, gaps now and then
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++)
                do_single(1'b1, mkv(j, 0), mkv(i, 3), mkv(i + j, 1), "R3");
            @(negedge clk);
        end
        repeat (6) @(negedge clk);

        // R4: alternating MUL/MAD on every clock
        for (int k = 0; k < 16; k++)
            do_single(k[0], mkv(k, 1), mkv(k + 2, 5), mkv(k + 4, 7), "R4");
        repeat (6) @(negedge clk);

        // R5: identity matrix returns the vector; then isolated transforms
        for (int k = 0; k < 4; k++)
            for (int l = 0; l < 4; l++)
                idv[k][32*l +: 32] = (k == l) ? 32'h0001_0000 : 32'h0;
        do_xform(mkv(7, 3), idv[0], idv[1], idv[2], idv[3], 1'b0, 1'b0, "R5");
        repeat (8) @(negedge clk);
        for (int t = 0; t < 4; t++) begin
            do_xform(mkv(t, 1), mkv(t + 1, 3), mkv(t + 2, 5), mkv(t + 3, 7), mkv(t + 4, 1), 1'b0, 1'b0, "R5");
            repeat (5) @(negedge clk);
        end

        // R9: back-to-back transforms, one result every four cycles
        for (int t = 0; t < 8; t++)
            do_xform(mkv(t + 5, 1), mkv(t, 1), mkv(t + 3, 1), mkv(t + 6, 5), mkv(t + 1, 3), 1'b0, 1'b0, "R9");
        // R4: single op directly after the last step of a transform
        do_single(1'b1, mkv(4, 1), mkv(5, 1), mkv(6, 1), "R4");
        repeat (8) @(negedge clk);

        // R6/R7: operands scrambled and decoy issues during the busy cycles
        for (int t = 0; t < 8; t++)
            do_xform(mkv(t + 2, 3), mkv(t + 4, 1), mkv(t, 5), mkv(t + 7, 3), mkv(t + 1, 1), 1'b1, 1'b0, "R6");
        repeat (8) @(negedge clk);

        // R8: start and single issue together, start wins
        do_xform(mkv(3, 1), mkv(4, 1), mkv(5, 3), mkv(6, 5), mkv(1, 7), 1'b0, 1'b1, "R8");
        do_xform(mkv(6, 1), mkv(2, 1), mkv(1, 3), mkv(0, 5), mkv(4, 7), 1'b1, 1'b1, "R8");

        repeat (12) @(negedge clk);
        check(rd_i == wr_i, "R10", "result pulse count", 128'(rd_i), 128'(wr_i));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule